// File: doc/BRIEF.md
# NAND Bus Cycle Decoder

This block sits on the device side of a NAND-style flash bus and turns the bus's asynchronous strobes into clean, typed events for a downstream core. All strobes are brought into a fast system clock domain through a two-flop synchroniser. The chip-enable, write-strobe and read-strobe lines also pass through a minimum-width filter, so that narrow glitches on them never become edges.

On every accepted rising edge of the write strobe, the block looks at the latch-select levels (command select, address select), the chip enable, the read strobe and write protect. It then emits one byte or word tagged as command, address or data input. Address cycles are counted, and the block flags the fifth one as completing the address. It rejects program and erase commands while write protect is asserted. Each falling edge of the read strobe during a read phase produces a one-cycle advance pulse. The block also drives the IO output enable, which stays off in standby.

Top module: `nand_cycle_decoder`

## Requirements
- R1: With chip enable low (ce_n_i=0), read strobe high, command select high and address select low, a write-strobe rising edge emits byte_valid_o with byte_kind_o=0 (command) and byte_data_o equal to io_i[7:0], with every upper bit zero.
- R2: With chip enable low, read strobe high, address select high and command select low, a write-strobe rising edge emits byte_kind_o=1 (address) with the low 8 IO bits. addr_idx_o gives the position of the byte within the address, counting 0 to 4 in arrival order.
- R3: With chip enable low, read strobe high, both selects low and wp_n_i high, a write-strobe rising edge emits byte_kind_o=2 (data) carrying all DATA_W bits of io_i. The same cycle with wp_n_i low emits nothing.
- R4: addr_done_o pulses together with the fifth address byte (addr_idx_o=4). Any later address cycle is not emitted and pulses addr_err_o instead.
- R5: An accepted command returns the address count to zero, so the next address byte carries addr_idx_o=0.
- R6: While wp_n_i is low, the program-setup code 0x80 and the erase-setup code 0x60 are not emitted and pulse wp_viol_o instead. Other command codes are still accepted.
- R7: Each falling edge of the read strobe with chip enable low, the write strobe high and both selects low gives exactly one rd_adv_o pulse. No pulse is given while chip enable is high.
- R8: A low pulse on ce_n_i, we_n_i or re_n_i that lasts fewer than FILT_LEN clock samples has no effect on any output.
- R9: io_oe_o is high only while chip enable and the read strobe are both low, with the write strobe high and both selects low. It is low in standby (ce_n_i=1) and after reset.
- R10: A write-strobe edge emits nothing when chip enable is high, when the read strobe is low, or when both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command select |
| ale_i | input | 1 | Address select |
| we_n_i | input | 1 | Write strobe, active low, latches on rising edge |
| re_n_i | input | 1 | Read strobe, active low |
| wp_n_i | input | 1 | Write protect, active low |
| io_i | input | DATA_W | Bus data in |
| byte_valid_o | output | 1 | One-cycle strobe for an emitted item |
| byte_kind_o | output | 2 | 0 command, 1 address, 2 data |
| byte_data_o | output | DATA_W | Emitted value |
| addr_idx_o | output | $clog2(ADDR_CYCLES+1) | Position of an address byte |
| addr_done_o | output | 1 | Address complete, with last address byte |
| addr_err_o | output | 1 | Excess address cycle dropped |
| wp_viol_o | output | 1 | Modify command rejected by write protect |
| rd_adv_o | output | 1 | Read advance pulse |
| io_oe_o | output | 1 | IO output driver enable |

## Verification
The bench first sends a command followed by a full five-byte address. It then sends a sixth address and a second command to separate correct counting from counter wrap and from a missing rewind. Data words with all sixteen bits set to distinct values show whether the data path is truncated, and a command driven with nonzero upper IO bits shows whether those bits are masked. The same modify and non-modify codes are sent with write protect high and low, which tells apart a correct opcode-specific block from blanket rejection or no rejection. Read pulses, two-sample glitches on each strobe, standby cycles and conflicting select levels check that only qualified, full-width edges produce events.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } byte_kind_e;

  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
endpackage

// File: rtl/nand_sync2.sv
module nand_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/nand_strobe_filter.sv
module nand_strobe_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_LVL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic lvl_o
);
  logic sync_w;

  nand_sync2 #(.W(1), .RST_VAL(RST_LVL)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  assign sync_o = sync_w;

  generate
    if (FILT_LEN <= 1) begin : g_nofilt
      assign lvl_o = sync_w;
    end else begin : g_filt
      localparam int CW = $clog2(FILT_LEN);
      logic [CW-1:0] run_q;
      logic          lvl_q;

      // level flips only after FILT_LEN consecutive differing samples
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          run_q <= '0;
          lvl_q <= RST_LVL;
        end else if (sync_w == lvl_q) begin
          run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
          run_q <= '0;
          lvl_q <= sync_w;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end

      assign lvl_o = lvl_q;

      assert_filter_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_w)));
    end
  endgenerate
endmodule

// File: rtl/nand_cycle_classifier.sv
module nand_cycle_classifier
  import nand_fe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_CYCLES = 5,
  localparam int IW         = $clog2(ADDR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_f_i,
  input  logic              we_f_i,
  input  logic              re_f_i,
  input  logic              cle_h_i,
  input  logic              ale_h_i,
  input  logic              cle_s_i,
  input  logic              ale_s_i,
  input  logic              wp_s_i,
  input  logic [DATA_W-1:0] io_h_i,
  output logic              byte_valid_o,
  output byte_kind_e        byte_kind_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic [IW-1:0]     addr_idx_o,
  output logic              addr_done_o,
  output logic              addr_err_o,
  output logic              wp_viol_o,
  output logic              rd_adv_o
);
  logic we_d_q, re_d_q;
  logic [IW-1:0] acnt_q;
  logic we_rise, re_fall, sel, is_cmd, is_addr, is_data, is_mod, rd_ok;

  assign we_rise = we_f_i & ~we_d_q;
  assign re_fall = ~re_f_i & re_d_q;
  assign sel     = we_rise & ~ce_f_i & re_f_i;
  assign is_cmd  = sel &  cle_h_i & ~ale_h_i;
  assign is_addr = sel &  ale_h_i & ~cle_h_i;
  assign is_data = sel & ~cle_h_i & ~ale_h_i;
  assign is_mod  = (io_h_i[7:0] == OP_PROG_SETUP) || (io_h_i[7:0] == OP_ERASE_SETUP);
  assign rd_ok   = re_fall & ~ce_f_i & we_f_i & ~cle_s_i & ~ale_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_d_q       <= 1'b1;
      re_d_q       <= 1'b1;
      acnt_q       <= '0;
      byte_valid_o <= 1'b0;
      byte_kind_o  <= KIND_CMD;
      byte_data_o  <= '0;
      addr_idx_o   <= '0;
      addr_done_o  <= 1'b0;
      addr_err_o   <= 1'b0;
      wp_viol_o    <= 1'b0;
      rd_adv_o     <= 1'b0;
    end else begin
      we_d_q       <= we_f_i;
      re_d_q       <= re_f_i;
      byte_valid_o <= 1'b0;
      addr_done_o  <= 1'b0;
      addr_err_o   <= 1'b0;
      wp_viol_o    <= 1'b0;
      rd_adv_o     <= rd_ok;
      if (is_cmd) begin
        if (is_mod && !wp_s_i) begin
          wp_viol_o <= 1'b1;
        end else begin
          byte_valid_o <= 1'b1;
          byte_kind_o  <= KIND_CMD;
          byte_data_o  <= DATA_W'(io_h_i[7:0]);
          addr_idx_o   <= '0;
          acnt_q       <= '0;
        end
      end else if (is_addr) begin
        if (acnt_q < IW'(ADDR_CYCLES)) begin
          byte_valid_o <= 1'b1;
          byte_kind_o  <= KIND_ADDR;
          byte_data_o  <= DATA_W'(io_h_i[7:0]);
          addr_idx_o   <= acnt_q;
          addr_done_o  <= (acnt_q == IW'(ADDR_CYCLES - 1));
          acnt_q       <= acnt_q + 1'b1;
        end else begin
          addr_err_o <= 1'b1;
        end
      end else if (is_data && wp_s_i) begin
        byte_valid_o <= 1'b1;
        byte_kind_o  <= KIND_DATA;
        byte_data_o  <= io_h_i;
      end
    end
  end

  assert_addr_idx_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_kind_o == KIND_ADDR) |-> (addr_idx_o < IW'(ADDR_CYCLES)));
  assert_data_needs_wp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_kind_o == KIND_DATA) |-> $past(wp_s_i));
  assert_done_on_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_o |-> (byte_valid_o && byte_kind_o == KIND_ADDR &&
                     addr_idx_o == IW'(ADDR_CYCLES - 1)));
  assert_err_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !byte_valid_o);
  assert_viol_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_viol_o |-> (!byte_valid_o && !$past(wp_s_i)));
  assert_cmd_is_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_kind_o == KIND_CMD) |-> (byte_data_o[DATA_W-1:8] == '0));
endmodule

// File: rtl/nand_cycle_decoder.sv
module nand_cycle_decoder
  import nand_fe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_CYCLES = 5,
  parameter int FILT_LEN    = 3,
  localparam int IW         = $clog2(ADDR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic              we_n_i,
  input  logic              re_n_i,
  input  logic              wp_n_i,
  input  logic [DATA_W-1:0] io_i,
  output logic              byte_valid_o,
  output logic [1:0]        byte_kind_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic [IW-1:0]     addr_idx_o,
  output logic              addr_done_o,
  output logic              addr_err_o,
  output logic              wp_viol_o,
  output logic              rd_adv_o,
  output logic              io_oe_o
);
  localparam int NSTB = 3;  // 0 ce, 1 we, 2 re

  logic [NSTB-1:0] stb_raw, stb_sync, stb_lvl;
  logic [2:0]      lvl_sel_s;
  logic [DATA_W-1:0] io_s, io_h_q;
  logic cle_h_q, ale_h_q, io_oe_q;
  logic ce_f, we_f, re_f, cle_s, ale_s, wp_s;
  byte_kind_e kind_w;

  assign stb_raw = {re_n_i, we_n_i, ce_n_i};

  generate
    for (genvar g = 0; g < NSTB; g++) begin : g_stb
      nand_strobe_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b1)) i_filt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (stb_raw[g]),
        .sync_o(stb_sync[g]),
        .lvl_o (stb_lvl[g])
      );
    end
  endgenerate

  assign ce_f = stb_lvl[0];
  assign we_f = stb_lvl[1];
  assign re_f = stb_lvl[2];

  nand_sync2 #(.W(3), .RST_VAL(3'b000)) i_sync_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wp_n_i, ale_i, cle_i}),
    .q_o   (lvl_sel_s)
  );
  assign cle_s = lvl_sel_s[0];
  assign ale_s = lvl_sel_s[1];
  assign wp_s  = lvl_sel_s[2];

  nand_sync2 #(.W(DATA_W), .RST_VAL('0)) i_sync_io (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (io_i),
    .q_o   (io_s)
  );

  // bus values frozen at the last sample before the write strobe returns high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_h_q  <= '0;
      cle_h_q <= 1'b0;
      ale_h_q <= 1'b0;
    end else if (!stb_sync[1]) begin
      io_h_q  <= io_s;
      cle_h_q <= cle_s;
      ale_h_q <= ale_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) io_oe_q <= 1'b0;
    else         io_oe_q <= ~ce_f & ~re_f & we_f & ~cle_s & ~ale_s;
  end
  assign io_oe_o = io_oe_q;

  nand_cycle_classifier #(.DATA_W(DATA_W), .ADDR_CYCLES(ADDR_CYCLES)) i_cls (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_f_i      (ce_f),
    .we_f_i      (we_f),
    .re_f_i      (re_f),
    .cle_h_i     (cle_h_q),
    .ale_h_i     (ale_h_q),
    .cle_s_i     (cle_s),
    .ale_s_i     (ale_s),
    .wp_s_i      (wp_s),
    .io_h_i      (io_h_q),
    .byte_valid_o(byte_valid_o),
    .byte_kind_o (kind_w),
    .byte_data_o (byte_data_o),
    .addr_idx_o  (addr_idx_o),
    .addr_done_o (addr_done_o),
    .addr_err_o  (addr_err_o),
    .wp_viol_o   (wp_viol_o),
    .rd_adv_o    (rd_adv_o)
  );
  assign byte_kind_o = kind_w;

  assert_oe_standby_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_f) |-> !io_oe_o);
  assert_events_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({byte_valid_o, addr_err_o, wp_viol_o}) <= 1);
  assert_rd_not_standby_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_adv_o |-> !$past(ce_f));
endmodule

// File: tb/test_nand_cycle_decoder.sv
module test_nand_cycle_decoder;
  localparam int DATA_W = 16;
  localparam int NADDR  = 5;
  localparam int FLEN   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [DATA_W-1:0] io = '0;
  logic byte_valid, addr_done, addr_err, wp_viol, rd_adv, io_oe;
  logic [1:0] byte_kind;
  logic [DATA_W-1:0] byte_data;
  logic [2:0] addr_idx;

  int errors = 0;
  int checks = 0;
  bit done_run = 0;
  bit oe_seen = 0;

  // expected events: kind 0 cmd, 1 addr, 2 data, 3 wp violation, 4 addr error, 5 read advance
  int    q_kind[$];
  int    q_data[$];
  int    q_idx[$];
  bit    q_done[$];
  string q_req[$];

  int  m_acnt = 0;

  always #5 clk = ~clk;

  nand_cycle_decoder #(.DATA_W(DATA_W), .ADDR_CYCLES(NADDR), .FILT_LEN(FLEN)) i_nand_cycle_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale),
    .we_n_i(we_n), .re_n_i(re_n), .wp_n_i(wp_n), .io_i(io),
    .byte_valid_o(byte_valid), .byte_kind_o(byte_kind), .byte_data_o(byte_data),
    .addr_idx_o(addr_idx), .addr_done_o(addr_done), .addr_err_o(addr_err),
    .wp_viol_o(wp_viol), .rd_adv_o(rd_adv), .io_oe_o(io_oe)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int k, int d, int idx, bit dn, string req);
    q_kind.push_back(k); q_data.push_back(d); q_idx.push_back(idx);
    q_done.push_back(dn); q_req.push_back(req);
  endtask

  // per-clock comparison against the expected event stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (io_oe) oe_seen = 1;
      if (byte_valid || addr_err || wp_viol || rd_adv) begin
        int k;
        k = byte_valid ? int'(byte_kind) : addr_err ? 4 : wp_viol ? 3 : 5;
        if (q_kind.size() == 0) begin
          check(0, "R10", "unexpected event kind", k, -1);
        end else begin
          int ek, ed, ei; bit edn; string r;
          ek = q_kind.pop_front(); ed = q_data.pop_front(); ei = q_idx.pop_front();
          edn = q_done.pop_front(); r = q_req.pop_front();
          check(k == ek, r, "event kind", k, ek);
          if (ek <= 2) check(int'(byte_data) == ed, r, "event data", int'(byte_data), ed);
          if (ek == 1) begin
            check(int'(addr_idx) == ei, r, "address index", int'(addr_idx), ei);
            check(addr_done == edn, r, "address done", int'(addr_done), int'(edn));
          end
        end
      end else if (addr_done) begin
        check(0, "R4", "stray address done", 1, 0);
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(string req);
    settle(6);
    check(q_kind.size() == 0, req, "missing events", q_kind.size(), 0);
    q_kind.delete(); q_data.delete(); q_idx.delete(); q_done.delete(); q_req.delete();
  endtask

  task automatic we_cycle(bit c, bit a, logic [DATA_W-1:0] d);
    @(negedge clk);
    cle = c; ale = a; io = d;
    settle(4);
    we_n = 0;
    settle(10);
    we_n = 1;
    settle(10);
    cle = 0; ale = 0;
    settle(4);
  endtask

  task automatic send_cmd(logic [7:0] code, logic [DATA_W-1:0] hi, string req);
    if ((code == 8'h80 || code == 8'h60) && !wp_n) begin
      push(3, 0, 0, 0, req);
    end else begin
      push(0, int'(code), 0, 0, req);
      m_acnt = 0;
    end
    we_cycle(1, 0, hi | DATA_W'(code));
    drain(req);
  endtask

  task automatic send_addr(logic [7:0] b, string req);
    if (m_acnt < NADDR) begin
      push(1, int'(b), m_acnt, (m_acnt == NADDR - 1), req);
      m_acnt++;
    end else begin
      push(4, 0, 0, 0, req);
    end
    we_cycle(0, 1, DATA_W'(b));
    drain(req);
  endtask

  task automatic send_data(logic [DATA_W-1:0] w, string req);
    if (wp_n) push(2, int'(w), 0, 0, req);
    we_cycle(0, 0, w);
    drain(req);
  endtask

  task automatic read_pulse(string req);
    if (!ce_n) push(5, 0, 0, 0, req);
    @(negedge clk);
    re_n = 0;
    settle(10);
    check(io_oe == !ce_n, "R9", "output enable during read", int'(io_oe), int'(!ce_n));
    re_n = 1;
    settle(10);
    check(io_oe == 1'b0, "R9", "output enable after read", int'(io_oe), 0);
    drain(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL all watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(2);
    check(!byte_valid && !addr_err && !wp_viol && !rd_adv && !addr_done, "R10",
          "reset event outputs", int'({byte_valid, addr_err, wp_viol, rd_adv}), 0);
    check(io_oe == 0, "R9", "reset output enable", int'(io_oe), 0);

    ce_n = 0;
    settle(8);
    send_cmd(8'h00, 16'h0000, "R1");
    send_addr(8'h11, "R2");
    send_addr(8'h22, "R2");
    send_addr(8'h33, "R2");
    send_addr(8'h44, "R2");
    send_addr(8'h55, "R4");
    send_addr(8'h66, "R4");
    send_cmd(8'h30, 16'h0000, "R5");
    send_addr(8'hA5, "R5");
    send_cmd(8'h80, 16'h0000, "R1");
    send_data(16'hBEEF, "R3");
    send_data(16'h1234, "R3");
    send_cmd(8'h12, 16'hAB00, "R1");

    wp_n = 0;
    settle(8);
    send_cmd(8'h60, 16'h0000, "R6");
    send_cmd(8'h80, 16'h0000, "R6");
    send_cmd(8'h90, 16'h0000, "R6");
    send_data(16'h5555, "R3");
    wp_n = 1;
    settle(8);

    we_cycle(1, 1, 16'h00EE);
    drain("R10");

    read_pulse("R7");
    read_pulse("R7");
    read_pulse("R7");

    // short glitches on each strobe
    @(negedge clk); re_n = 0; settle(FLEN - 1); re_n = 1; settle(12);
    drain("R8");
    @(negedge clk); cle = 1; io = 16'h0070; settle(4);
    we_n = 0; settle(FLEN - 1); we_n = 1; settle(12); cle = 0;
    drain("R8");
    ce_n = 1; settle(8);
    re_n = 0; settle(8);
    oe_seen = 0;
    ce_n = 0; settle(FLEN - 1); ce_n = 1; settle(12);
    check(oe_seen == 0, "R8", "chip enable glitch raised output enable", int'(oe_seen), 0);
    re_n = 1; settle(8);
    drain("R8");

    // standby
    we_cycle(1, 0, 16'h00FF);
    drain("R10");
    read_pulse("R7");

    // read strobe low across a write edge
    ce_n = 0; settle(8);
    push(5, 0, 0, 0, "R7");
    @(negedge clk); re_n = 0; settle(10);
    we_cycle(1, 0, 16'h0070);
    re_n = 1; settle(8);
    drain("R10");

    send_cmd(8'h00, 16'h0000, "R5");
    send_addr(8'h01, "R5");

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule